// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block takes a command word and a 32-bit argument from register writes. It sends the command to a card-side request/response port and stores the reply in four 32-bit response words. Writing the command register with the start flag set launches a request. The request carries the command index and the argument. It waits for the handshake and then waits for the card's reply. The reply reports one of four length codes, and the block checks that code against what the command asked for.

A good reply is loaded into the response words: a short reply goes to word 0, and a long reply is spread across all four words with the last bytes in word 0. A reply whose length does not match the request raises the fail flag in the command register and the command-timeout status bit. A successful command that asked for busy-wait raises the busy-interrupt status bit, provided that interrupt is enabled. The start flag clears itself once the reply has been handled. A busy output covers the whole exchange, and writes to the command or argument register during that window are dropped.

Top module: `sdcmd_issue`

## Requirements
- R1: After reset the command word, status word and all response words read zero, and `busy` and `card_req_valid` are low.
- R2: A command-register write (select 0) whose bit 15 is set, made while not busy, raises `card_req_valid` and `busy` on the next cycle. The request carries command bits 5:0 as the index and the argument register (select 1) as the argument. `card_req_valid` stays high until a cycle with `card_req_ready` high, and falls after that cycle.
- R3: A command-register write with bit 15 clear stores the word but issues no request.
- R4: While `busy` is high, writes to the command register and to the argument register are ignored.
- R5: In the cycle after `card_rsp_valid` is seen while waiting, `busy` is low and command bit 15 reads zero. All other command bits keep their written value, except the fail flag described in R8.
- R6: A short reply (length code 1) is accepted when command bit 10 (no response) is clear and bit 9 (long) is clear. It loads word 0 with `card_rsp_data[127:96]`, where the first byte received is the most significant, and clears words 1 to 3.
- R7: A long reply (length code 2) is accepted when bit 10 is clear, whether or not bit 9 is set. It loads word k with `card_rsp_data[32k+31:32k]`, so the last four bytes received land in word 0 and the first four in word 3.
- R8: Each of the following is a failure: length code 3; length code 0 while bit 10 is clear; length code 1 while bit 9 is set. On a failure, command bit 14 and status bit 6 are set, and the response words keep their previous contents.
- R9: When bit 10 is set, length codes 0, 1 and 2 complete without failure and leave the response words unchanged.
- R10: Status bit 10 is set when a command finishes without failure, its bit 11 (busy-wait) is set, and config bit 10 (select 2) is set. It is not set when either of those bits is clear, and it is not set when the command fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select: 0 command, 1 argument, 2 config |
| reg_wr_data | input | 32 | Register write data |
| cmd_word | output | 32 | Command register contents |
| status_word | output | 32 | Status register contents |
| rsp_words | output | 128 | Response words, word k at bits 32k+31:32k |
| busy | output | 1 | High from issue until the reply is captured |
| card_req_valid | output | 1 | Request to the card is pending |
| card_req_ready | input | 1 | Card accepts the request |
| card_req_index | output | 6 | Command index |
| card_req_arg | output | 32 | Command argument |
| card_rsp_valid | input | 1 | Card reply present |
| card_rsp_len | input | 2 | Reply length: 0 none, 1 short, 2 long, 3 error |
| card_rsp_data | input | 128 | Reply bytes, first byte in bits 127:120 |

## Verification
The bench builds the block with its default parameters: a 6-bit index, 32-bit words and four response words. With these values every word-order corner can be reached, including each word of a long reply and the clearing of words 1 to 3 after a short reply. Each scenario uses distinct byte patterns, so a swapped or shifted word gives a visibly wrong value. The card model holds off `card_req_ready` for several cycles, which keeps the block busy long enough to test the ignored register writes.

// File: rtl/sdc_pkg.sv
// Package: shared encodings for the SD command issue block.
// Assumes a 16-bit meaningful command field inside a 32-bit register.
package sdc_pkg;
    typedef enum logic [1:0] {
        LEN_NONE  = 2'd0,
        LEN_SHORT = 2'd1,
        LEN_LONG  = 2'd2,
        LEN_FAULT = 2'd3
    } rsp_len_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } issue_state_e;

    localparam int START_BIT       = 15;
    localparam int FAIL_BIT        = 14;
    localparam int BUSYWAIT_BIT    = 11;
    localparam int NORSP_BIT       = 10;
    localparam int LONG_BIT        = 9;
    localparam int STS_TIMEOUT_BIT = 6;
    localparam int STS_BUSYIRQ_BIT = 10;
    localparam int CFG_BUSYIRQ_BIT = 10;

    localparam logic [1:0] SEL_CMD = 2'd0;
    localparam logic [1:0] SEL_ARG = 2'd1;
    localparam logic [1:0] SEL_CFG = 2'd2;
endpackage

// File: rtl/sdc_issue_fsm.sv
// Module: sequencer for one command exchange.
// It moves from idle to request on start, holds the request until it is
// accepted, then waits for a reply. It assumes start arrives only when idle.
module sdc_issue_fsm
    import sdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic req_ready,
    input  logic rsp_valid,
    output logic req_valid,
    output logic busy,
    output logic done
);
    issue_state_e state_q;

    // Purpose: advance the exchange state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (start)     state_q <= ST_REQ;
                ST_REQ:  if (req_ready) state_q <= ST_WAIT;
                ST_WAIT: if (rsp_valid) state_q <= ST_IDLE;
                default:                state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: derive the handshake and progress outputs from the state.
    always_comb begin
        req_valid = (state_q == ST_REQ);
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_WAIT) && rsp_valid;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid); // R2
    AST_START_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> req_valid && busy); // R2
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R5
endmodule

// File: rtl/sdc_rsp_judge.sv
// Module: compares the reply length with the length the command expects.
// It is purely combinational. The load output is meaningful only when a
// reply is present.
module sdc_rsp_judge
    import sdc_pkg::*;
(
    input  logic       no_rsp,
    input  logic       want_long,
    input  logic [1:0] len,
    output logic       fault,
    output logic       load,
    output logic       is_long
);
    // Purpose: classify the reply as a failure, a load or neither.
    always_comb begin
        fault   = (len == LEN_FAULT) ||
                  (!no_rsp && (len == LEN_NONE)) ||
                  (!no_rsp && want_long && (len == LEN_SHORT));
        load    = !fault && !no_rsp && ((len == LEN_SHORT) || (len == LEN_LONG));
        is_long = (len == LEN_LONG);
    end
endmodule

// File: rtl/sdc_rsp_store.sv
// Module: response word storage.
// A long load copies reply word k into word k, so the last bytes received
// land in word 0. A short load puts the first word received into word 0
// and clears the rest.
module sdc_rsp_store #(
    parameter int WORD_W = 32,
    parameter int NWORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     is_long,
    input  logic [NWORDS*WORD_W-1:0] data,
    output logic [NWORDS*WORD_W-1:0] rsp
);
    localparam int TOTAL_W = NWORDS * WORD_W;
    localparam int TOP_LSB = TOTAL_W - WORD_W;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [WORD_W-1:0] short_val;
        if (w == 0) begin : g_first
            assign short_val = data[TOP_LSB +: WORD_W];
        end else begin : g_rest
            assign short_val = '0;
        end

        // Purpose: load one response word on a good reply.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rsp[w*WORD_W +: WORD_W] <= '0;
            end else if (load) begin
                rsp[w*WORD_W +: WORD_W] <= is_long ? data[w*WORD_W +: WORD_W] : short_val;
            end
        end
    end

    AST_SHORT_CLEARS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        load && !is_long |=> rsp[TOTAL_W-1:WORD_W] == '0); // R6
    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(rsp)); // R8
endmodule

// File: rtl/sdcmd_issue.sv
// Module: SD command issue and response capture, top level.
// It holds the command, argument, config and status registers. It launches
// an exchange when the command word is written with the start flag, and it
// records the outcome when the reply arrives. It assumes the card answers
// each accepted request with exactly one reply.
module sdcmd_issue
    import sdc_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int REG_W  = 32,
    parameter int NWORDS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr_en,
    input  logic [1:0]              reg_wr_sel,
    input  logic [REG_W-1:0]        reg_wr_data,
    output logic [REG_W-1:0]        cmd_word,
    output logic [REG_W-1:0]        status_word,
    output logic [NWORDS*REG_W-1:0] rsp_words,
    output logic                    busy,
    output logic                    card_req_valid,
    input  logic                    card_req_ready,
    output logic [IDX_W-1:0]        card_req_index,
    output logic [REG_W-1:0]        card_req_arg,
    input  logic                    card_rsp_valid,
    input  logic [1:0]              card_rsp_len,
    input  logic [NWORDS*REG_W-1:0] card_rsp_data
);
    logic [REG_W-1:0] cmd_q, arg_q, sts_q;
    logic             cfg_busy_en_q;
    logic             wr_cmd, wr_arg, start, done;
    logic             fault, load, is_long;

    // Purpose: decode register writes, dropping command and argument writes while busy.
    always_comb begin
        wr_cmd = reg_wr_en && (reg_wr_sel == SEL_CMD) && !busy;
        wr_arg = reg_wr_en && (reg_wr_sel == SEL_ARG) && !busy;
        start  = wr_cmd && reg_wr_data[START_BIT];
    end

    sdc_issue_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_ready (card_req_ready),
        .rsp_valid (card_rsp_valid),
        .req_valid (card_req_valid),
        .busy      (busy),
        .done      (done)
    );

    sdc_rsp_judge u_judge (
        .no_rsp    (cmd_q[NORSP_BIT]),
        .want_long (cmd_q[LONG_BIT]),
        .len       (card_rsp_len),
        .fault     (fault),
        .load      (load),
        .is_long   (is_long)
    );

    sdc_rsp_store #(.WORD_W(REG_W), .NWORDS(NWORDS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (done && load),
        .is_long (is_long),
        .data    (card_rsp_data),
        .rsp     (rsp_words)
    );

    // Purpose: command register, self-clearing start flag and fail flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_cmd) begin
            cmd_q <= reg_wr_data;
        end else if (done) begin
            cmd_q[START_BIT] <= 1'b0;
            if (fault) cmd_q[FAIL_BIT] <= 1'b1;
        end
    end

    // Purpose: argument and config registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q         <= '0;
            cfg_busy_en_q <= 1'b0;
        end else begin
            if (wr_arg) arg_q <= reg_wr_data;
            if (reg_wr_en && (reg_wr_sel == SEL_CFG))
                cfg_busy_en_q <= reg_wr_data[CFG_BUSYIRQ_BIT];
        end
    end

    // Purpose: sticky status bits for timeout and busy interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else if (done) begin
            if (fault)
                sts_q[STS_TIMEOUT_BIT] <= 1'b1;
            else if (cmd_q[BUSYWAIT_BIT] && cfg_busy_en_q)
                sts_q[STS_BUSYIRQ_BIT] <= 1'b1;
        end
    end

    assign cmd_word       = cmd_q;
    assign status_word    = sts_q;
    assign card_req_index = cmd_q[IDX_W-1:0];
    assign card_req_arg   = arg_q;

    AST_START_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !cmd_word[START_BIT]); // R5
    AST_FAULT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |=> cmd_word[FAIL_BIT] && status_word[STS_TIMEOUT_BIT]); // R8
    AST_BUSY_LOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> $stable(cmd_word) && $stable(card_req_arg)); // R4
    AST_IRQ_ONLY_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |=> $stable(status_word[STS_BUSYIRQ_BIT])); // R10
endmodule

// File: tb/sdcmd_issue_test.sv
// Directed bench: one task per scenario, each task checks its own results.
module sdcmd_issue_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic [1:0]   reg_wr_sel = 2'd0;
    logic [31:0]  reg_wr_data = '0;
    logic [31:0]  cmd_word, status_word, card_req_arg;
    logic [127:0] rsp_words;
    logic         busy, card_req_valid;
    logic         card_req_ready = 1'b0;
    logic [5:0]   card_req_index;
    logic         card_rsp_valid = 1'b0;
    logic [1:0]   card_rsp_len = 2'd0;
    logic [127:0] card_rsp_data = '0;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    sdcmd_issue uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .cmd_word(cmd_word), .status_word(status_word),
        .rsp_words(rsp_words), .busy(busy), .card_req_valid(card_req_valid),
        .card_req_ready(card_req_ready), .card_req_index(card_req_index),
        .card_req_arg(card_req_arg), .card_rsp_valid(card_rsp_valid),
        .card_rsp_len(card_rsp_len), .card_rsp_data(card_rsp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // One full exchange; exp_arg is the argument the request must carry.
    task automatic run_cmd(input logic [31:0] cw, input bit set_arg, input logic [31:0] arg,
                           input logic [1:0] len, input logic [127:0] d);
        if (set_arg) write_reg(2'd1, arg);
        write_reg(2'd0, cw);
        chk(card_req_valid && busy, "R2 request raised", {card_req_valid, busy}, 2'b11);
        chk(card_req_index == cw[5:0], "R2 index", card_req_index, cw[5:0]);
        chk(card_req_arg == arg, "R2 argument", card_req_arg, arg);
        write_reg(2'd0, 32'h0000_0000);
        chk(cmd_word == cw, "R4 command write ignored while busy", cmd_word, cw);
        write_reg(2'd1, 32'hDEAD_BEEF);
        chk(card_req_valid, "R2 valid held until ready", card_req_valid, 1'b1);
        card_req_ready = 1'b1;
        @(negedge clk); card_req_ready = 1'b0;
        chk(!card_req_valid && busy, "R2 valid drops after handshake", {card_req_valid, busy}, 2'b01);
        @(negedge clk);
        card_rsp_valid = 1'b1; card_rsp_len = len; card_rsp_data = d;
        @(negedge clk);
        card_rsp_valid = 1'b0;
        chk(!busy, "R5 busy low after reply", busy, 1'b0);
    endtask

    task automatic t_reset();
        do_reset();
        chk(cmd_word == 0 && status_word == 0 && rsp_words == 0, "R1 registers zero",
            {cmd_word, status_word}, 0);
        chk(!busy && !card_req_valid, "R1 idle outputs", {busy, card_req_valid}, 0);
    endtask

    task automatic t_no_start();
        do_reset();
        write_reg(2'd0, 32'h0000_0425);
        @(negedge clk);
        chk(cmd_word == 32'h0425, "R3 word stored", cmd_word, 32'h0425);
        chk(!card_req_valid && !busy, "R3 no request", {card_req_valid, busy}, 0);
    endtask

    task automatic t_long_then_short();
        logic [127:0] dl = 128'h0102_0304_1112_1314_2122_2324_3132_3334;
        logic [127:0] ds = 128'hA1B2_C3D4_5555_6666_7777_8888_9999_AAAA;
        do_reset();
        run_cmd(32'h0000_8202, 1'b1, 32'h1234_5678, 2'd2, dl);
        chk(rsp_words == dl, "R7 long word order", rsp_words, dl);
        chk(cmd_word == 32'h0202, "R5 start cleared", cmd_word, 32'h0202);
        run_cmd(32'h0000_8011, 1'b0, 32'h1234_5678, 2'd1, ds);
        chk(rsp_words == {96'h0, 32'hA1B2_C3D4}, "R6 short load and clear", rsp_words,
            {96'h0, 32'hA1B2_C3D4});
        chk(status_word == 0, "R6 no status on success", status_word, 0);
        run_cmd(32'h0000_8003, 1'b0, 32'h1234_5678, 2'd2, dl);
        chk(rsp_words == dl, "R7 long reply on short request", rsp_words, dl);
    endtask

    task automatic t_errors();
        logic [127:0] dl = 128'hF0F1_F2F3_E0E1_E2E3_D0D1_D2D3_C0C1_C2C3;
        do_reset();
        run_cmd(32'h0000_8202, 1'b1, 32'h0000_0001, 2'd2, dl);
        run_cmd(32'h0000_8204, 1'b1, 32'h0000_0002, 2'd1, ~dl);
        chk(cmd_word == 32'h4204, "R8 fail flag short-for-long", cmd_word, 32'h4204);
        chk(status_word == 32'h0040, "R8 timeout status", status_word, 32'h0040);
        chk(rsp_words == dl, "R8 response kept", rsp_words, dl);
        do_reset();
        run_cmd(32'h0000_8005, 1'b1, 32'h0000_0003, 2'd0, dl);
        chk(cmd_word == 32'h4005 && status_word == 32'h0040, "R8 empty reply fails",
            {cmd_word, status_word}, {32'h4005, 32'h0040});
        chk(rsp_words == 0, "R8 response kept on empty reply", rsp_words, 0);
        do_reset();
        run_cmd(32'h0000_8406, 1'b1, 32'h0000_0004, 2'd3, dl);
        chk(cmd_word == 32'h4406 && status_word == 32'h0040, "R8 error code fails",
            {cmd_word, status_word}, {32'h4406, 32'h0040});
    endtask

    task automatic t_no_rsp();
        logic [127:0] dl = 128'h0A0B_0C0D_1A1B_1C1D_2A2B_2C2D_3A3B_3C3D;
        do_reset();
        run_cmd(32'h0000_8202, 1'b1, 32'h0000_0009, 2'd2, dl);
        run_cmd(32'h0000_8407, 1'b1, 32'h0000_000A, 2'd1, ~dl);
        chk(rsp_words == dl && cmd_word == 32'h0407 && status_word == 0,
            "R9 short reply ignored", rsp_words, dl);
        run_cmd(32'h0000_8407, 1'b1, 32'h0000_000B, 2'd0, ~dl);
        chk(cmd_word == 32'h0407 && status_word == 0, "R9 empty reply accepted",
            {cmd_word, status_word}, {32'h0407, 32'h0});
    endtask

    task automatic t_busy_irq();
        logic [127:0] d = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
        do_reset();
        write_reg(2'd2, 32'h0000_0400);
        run_cmd(32'h0000_8808, 1'b1, 32'h0000_0042, 2'd1, d);
        chk(status_word == 32'h0400, "R10 busy irq set", status_word, 32'h0400);
        do_reset();
        run_cmd(32'h0000_8808, 1'b1, 32'h0000_0042, 2'd1, d);
        chk(status_word == 0, "R10 disabled by config", status_word, 0);
        do_reset();
        write_reg(2'd2, 32'h0000_0400);
        run_cmd(32'h0000_8A08, 1'b1, 32'h0000_0042, 2'd1, d);
        chk(status_word == 32'h0040, "R10 not on failure", status_word, 32'h0040);
        do_reset();
        write_reg(2'd2, 32'h0000_0400);
        run_cmd(32'h0000_8008, 1'b1, 32'h0000_0042, 2'd1, d);
        chk(status_word == 0, "R10 not without busy-wait", status_word, 0);
    endtask

    task automatic t_arg_locked();
        logic [127:0] d = 128'h9999_8888_7777_6666_5555_4444_3333_2222;
        do_reset();
        run_cmd(32'h0000_8011, 1'b1, 32'h00C0_FFEE, 2'd1, d);
        // run_cmd writes DEADBEEF to the argument while busy; it must not stick (R4)
        run_cmd(32'h0000_8012, 1'b0, 32'h00C0_FFEE, 2'd1, d);
        chk(cmd_word == 32'h0012, "R4 next command completes", cmd_word, 32'h0012);
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_no_start();
        t_long_then_short();
        t_errors();
        t_no_rsp();
        t_busy_irq();
        t_arg_locked();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule